// File: doc/BRIEF.md
# Byte Register-File ALU Datapath

An 8-bit execution datapath built around sixteen interchangeable byte registers and a small scratchpad RAM. On each cycle with `valid_i` high it takes a decoded operation, a destination/first-operand register index sX, and a second operand. That operand is either register sY or an 8-bit immediate, chosen by `use_imm_i`. The result goes back into sX, so the machine is destructive and two-operand, with no accumulator. A ZERO flag and a CARRY flag are kept across operations. Compare and test compute a result only to set those flags.

Scratchpad store and fetch take their address from the low bits of the second operand, whether that operand is the immediate or sY. Every accepted operation reports its result on `res_o` one clock later, together with `res_valid_o` and the updated flags. This lets the surrounding sequencer observe each step. Instruction fetch, I/O ports and interrupts belong to other blocks.

Top module: `byte_alu_core`

## Requirements
- R1: After reset, all sixteen registers and every scratchpad byte hold 0x00, `zero_o` and `carry_o` are 0, and `res_valid_o` is low.
- R2: The second operand is the immediate when `use_imm_i` is 1 and register sY when it is 0. Move (op code 0) copies it into sX and reports it on `res_o`. Any writing operation stores its result in sX.
- R3: Add (code 1) writes sX+operand. Add-with-carry (code 2) also adds the current CARRY. Both set CARRY to the carry-out of bit 7.
- R4: Subtract (code 3) writes sX−operand. Subtract-with-borrow (code 4) also subtracts the current CARRY. Both set CARRY to the borrow.
- R5: AND (code 5), OR (code 6) and XOR (code 7) write the bitwise result and clear CARRY.
- R6: Compare (code 8) reports sX−operand on `res_o`, sets CARRY when sX < operand, and sets ZERO when they are equal. It leaves sX unchanged.
- R7: Test (code 9) reports sX AND operand, sets ZERO when that is zero, and sets CARRY to its odd parity. It leaves sX unchanged.
- R8: Shift left (code 10) fills bit 0 with 0. Shift right (code 11) fills bit 7 with 0. Rotate left (code 12) and rotate right (code 13) wrap the end bit around. In all four cases CARRY takes the bit that leaves the byte, and the second operand is ignored.
- R9: For codes 1 to 13, ZERO is set exactly when the reported result is 0x00.
- R10: Store (code 14) writes sX into the scratchpad and reports sX. Fetch (code 15) loads a scratchpad byte into sX and reports it. The address is the low six bits of the second operand.
- R11: Move, store and fetch leave both flags unchanged. `res_valid_o` rises one cycle after each accepted operation, and cycles without `valid_i` change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Execute the presented operation this cycle |
| op_i | input | 4 | Decoded operation code |
| sx_i | input | 4 | First operand and destination register index |
| sy_i | input | 4 | Second operand register index |
| imm_i | input | 8 | Immediate second operand |
| use_imm_i | input | 1 | 1 selects the immediate, 0 selects register sY |
| res_valid_o | output | 1 | Result of the previous cycle's operation is present |
| res_o | output | 8 | Result of the last accepted operation |
| zero_o | output | 1 | ZERO flag |
| carry_o | output | 1 | CARRY flag |

## Verification
The bench builds the block with its default parameters: 8-bit data, sixteen registers and a 64-entry scratchpad. At that size the scratchpad address is six bits wide. An immediate such as 0xC5 and a register holding 0x45 then reach the same entry, which exercises the address-truncation rule. The eight-bit width also brings add and subtract wraparound within reach, as well as chained carry and borrow and a shift that empties the byte.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;
  typedef enum logic [3:0] {
    OP_MOVE  = 4'd0,
    OP_ADD   = 4'd1,
    OP_ADDC  = 4'd2,
    OP_SUB   = 4'd3,
    OP_SUBC  = 4'd4,
    OP_AND   = 4'd5,
    OP_OR    = 4'd6,
    OP_XOR   = 4'd7,
    OP_CMP   = 4'd8,
    OP_TEST  = 4'd9,
    OP_SHL   = 4'd10,
    OP_SHR   = 4'd11,
    OP_ROL   = 4'd12,
    OP_ROR   = 4'd13,
    OP_STORE = 4'd14,
    OP_FETCH = 4'd15
  } alu_op_e;

  function automatic logic touches_flags(alu_op_e op);
    return !(op inside {OP_MOVE, OP_STORE, OP_FETCH});
  endfunction
endpackage

// File: rtl/bra_regfile.sv
module bra_regfile #(
  parameter int DW   = 8,
  parameter int NREG = 16,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [RW-1:0] wa_i,
  input  logic [DW-1:0] wd_i,
  input  logic [RW-1:0] ra_a_i,
  output logic [DW-1:0] rd_a_o,
  input  logic [RW-1:0] ra_b_i,
  output logic [DW-1:0] rd_b_o
);
  logic [DW-1:0] regs_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we_i) begin
      regs_q[wa_i] <= wd_i;
    end
  end

  assign rd_a_o = regs_q[ra_a_i];
  assign rd_b_o = regs_q[ra_b_i];

  // R2: a write lands in the addressed register
  a_r2_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> regs_q[$past(wa_i)] == $past(wd_i));
endmodule

// File: rtl/bra_scratch.sv
module bra_scratch #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wd_i,
  output logic [DW-1:0] rd_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[addr_i] <= wd_i;
    end
  end

  assign rd_o = mem_q[addr_i];

  // R10: stored byte is readable at the same address next cycle
  a_r10_store_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(addr_i)] == $past(wd_i));
endmodule

// File: rtl/bra_alu.sv
module bra_alu
  import byte_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          c_i,
  output logic [DW-1:0] res_o,
  output logic          c_o,
  output logic          z_o,
  output logic          rf_we_o
);
  logic [DW:0] sum, dif;
  logic [DW:0] cin;

  assign cin = {{DW{1'b0}}, c_i};
  assign sum = {1'b0, a_i} + {1'b0, b_i} + ((op_i == OP_ADDC) ? cin : '0);
  assign dif = {1'b0, a_i} - {1'b0, b_i} - ((op_i == OP_SUBC) ? cin : '0);

  always_comb begin
    res_o   = a_i;
    c_o     = c_i;
    rf_we_o = 1'b1;
    unique case (op_i)
      OP_MOVE:                 res_o = b_i;
      OP_ADD, OP_ADDC:         {c_o, res_o} = sum;
      OP_SUB, OP_SUBC:         {c_o, res_o} = dif;
      OP_CMP: begin
        {c_o, res_o} = dif;
        rf_we_o = 1'b0;
      end
      OP_AND: begin res_o = a_i & b_i; c_o = 1'b0; end
      OP_OR:  begin res_o = a_i | b_i; c_o = 1'b0; end
      OP_XOR: begin res_o = a_i ^ b_i; c_o = 1'b0; end
      OP_TEST: begin
        res_o   = a_i & b_i;
        c_o     = ^(a_i & b_i);
        rf_we_o = 1'b0;
      end
      OP_SHL: begin res_o = {a_i[DW-2:0], 1'b0};     c_o = a_i[DW-1]; end
      OP_SHR: begin res_o = {1'b0, a_i[DW-1:1]};     c_o = a_i[0];    end
      OP_ROL: begin res_o = {a_i[DW-2:0], a_i[DW-1]}; c_o = a_i[DW-1]; end
      OP_ROR: begin res_o = {a_i[0], a_i[DW-1:1]};   c_o = a_i[0];    end
      OP_STORE:                rf_we_o = 1'b0;
      OP_FETCH:                res_o = a_i; // replaced by RAM data at top
      default:                 rf_we_o = 1'b0;
    endcase
  end

  assign z_o = (res_o == '0);

  // R8: rotation neither creates nor destroys set bits
  always_comb begin
    if (op_i == OP_ROL || op_i == OP_ROR)
      a_r8_rotate_keeps_ones: assert ($countones(res_o) == $countones(a_i));
  end
endmodule

// File: rtl/byte_alu_core.sv
module byte_alu_core
  import byte_alu_pkg::*;
#(
  parameter int DW       = 8,
  parameter int NREG     = 16,
  parameter int SP_DEPTH = 64,
  localparam int RW      = $clog2(NREG),
  localparam int AW      = $clog2(SP_DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [3:0]    op_i,
  input  logic [RW-1:0] sx_i,
  input  logic [RW-1:0] sy_i,
  input  logic [DW-1:0] imm_i,
  input  logic          use_imm_i,
  output logic          res_valid_o,
  output logic [DW-1:0] res_o,
  output logic          zero_o,
  output logic          carry_o
);
  alu_op_e       op;
  logic [DW-1:0] rd_a, rd_b, opnd_b, alu_res, sp_rd, wb_data;
  logic          alu_c, alu_z, alu_we;
  logic [AW-1:0] sp_addr;

  assign op      = alu_op_e'(op_i);
  assign opnd_b  = use_imm_i ? imm_i : rd_b;
  assign sp_addr = opnd_b[AW-1:0];
  assign wb_data = (op == OP_FETCH) ? sp_rd : alu_res;

  bra_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk_i, .rst_ni,
    .we_i   (valid_i && alu_we),
    .wa_i   (sx_i),
    .wd_i   (wb_data),
    .ra_a_i (sx_i),
    .rd_a_o (rd_a),
    .ra_b_i (sy_i),
    .rd_b_o (rd_b)
  );

  bra_scratch #(.DW(DW), .DEPTH(SP_DEPTH)) u_sp (
    .clk_i, .rst_ni,
    .we_i   (valid_i && op == OP_STORE),
    .addr_i (sp_addr),
    .wd_i   (rd_a),
    .rd_o   (sp_rd)
  );

  bra_alu #(.DW(DW)) u_alu (
    .op_i    (op),
    .a_i     (rd_a),
    .b_i     (opnd_b),
    .c_i     (carry_o),
    .res_o   (alu_res),
    .c_o     (alu_c),
    .z_o     (alu_z),
    .rf_we_o (alu_we)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_o       <= '0;
      zero_o      <= 1'b0;
      carry_o     <= 1'b0;
    end else begin
      res_valid_o <= valid_i;
      if (valid_i) begin
        res_o <= wb_data;
        if (touches_flags(op)) begin
          zero_o  <= alu_z;
          carry_o <= alu_c;
        end
      end
    end
  end

  // R11: one result strobe per accepted operation
  a_r11_strobe_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> res_valid_o);
  a_r11_idle_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !res_valid_o && $stable(zero_o) && $stable(carry_o));
  // R11: move/store/fetch keep flags
  a_r11_flags_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i inside {4'd0, 4'd14, 4'd15}) |=> $stable(zero_o) && $stable(carry_o));
  // R9: zero flag tracks the reported result
  a_r9_zero_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i inside {[4'd1:4'd13]}) |=> zero_o == (res_o == '0));
  // R5: logic ops clear carry
  a_r5_logic_clears_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i inside {4'd5, 4'd6, 4'd7}) |=> !carry_o);
endmodule

// File: tb/test_byte_alu_core.sv
module test_byte_alu_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic [3:0] op = '0, sx = '0, sy = '0;
  logic [7:0] imm = '0;
  logic       use_imm = 1'b0;
  logic       res_valid, zero, carry;
  logic [7:0] res;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk; // 50 MHz

  byte_alu_core i_byte_alu_core (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .sx_i(sx), .sy_i(sy),
    .imm_i(imm), .use_imm_i(use_imm), .res_valid_o(res_valid), .res_o(res),
    .zero_o(zero), .carry_o(carry)
  );

  typedef struct {
    logic [7:0] r;
    logic z;
    logic c;
    string tag;
  } exp_t;
  exp_t q[$];

  logic [7:0] m_reg [16];
  logic [7:0] m_ram [64];
  logic m_z = 0, m_c = 0;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] o, input logic [3:0] x, input logic [3:0] y,
                       input logic [7:0] im, input bit ui, input string tag);
    logic [7:0] a, b, r;
    logic [8:0] t;
    logic c, wr;
    exp_t e;
    a = m_reg[x];
    b = ui ? im : m_reg[y];
    r = a; c = m_c; wr = 1;
    case (o)
      4'd0: r = b;
      4'd1: begin t = {1'b0, a} + {1'b0, b}; {c, r} = t; end
      4'd2: begin t = {1'b0, a} + {1'b0, b} + {8'd0, m_c}; {c, r} = t; end
      4'd3: begin t = {1'b0, a} - {1'b0, b}; {c, r} = t; end
      4'd4: begin t = {1'b0, a} - {1'b0, b} - {8'd0, m_c}; {c, r} = t; end
      4'd5: begin r = a & b; c = 0; end
      4'd6: begin r = a | b; c = 0; end
      4'd7: begin r = a ^ b; c = 0; end
      4'd8: begin r = a - b; c = (a < b); wr = 0; end
      4'd9: begin r = a & b; c = ^r; wr = 0; end
      4'd10: begin r = a << 1; c = a[7]; end
      4'd11: begin r = a >> 1; c = a[0]; end
      4'd12: begin r = {a[6:0], a[7]}; c = a[7]; end
      4'd13: begin r = {a[0], a[7:1]}; c = a[0]; end
      4'd14: begin m_ram[b[5:0]] = a; wr = 0; end
      default: r = m_ram[b[5:0]];
    endcase
    if (wr) m_reg[x] = r;
    if (o >= 4'd1 && o <= 4'd13) begin m_z = (r == 8'h00); m_c = c; end
    e.r = r; e.z = m_z; e.c = m_c; e.tag = tag;
    @(negedge clk);
    op = o; sx = x; sy = y; imm = im; use_imm = ui; valid = 1'b1;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid = 1'b0;
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (res_valid) begin
        if (q.size() == 0) begin
          check(0, "R11", "unexpected strobe", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(res == e.r, e.tag, "res", res, e.r);
          check(zero == e.z, e.tag, "zero", zero, e.z);
          check(carry == e.c, e.tag, "carry", carry, e.c);
        end
      end
    end
  end

  // watchdog
  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) m_reg[i] = 8'h00;
    for (int i = 0; i < 64; i++) m_ram[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(res_valid == 0, "R1", "res_valid", res_valid, 0);
    check(zero == 0, "R1", "zero", zero, 0);
    check(carry == 0, "R1", "carry", carry, 0);
    rst_n = 1'b1;
    issue(4'd6, 4'd3, 4'd0, 8'h00, 1, "R1");   // s3 reads zero
    issue(4'd15, 4'd4, 4'd0, 8'h3F, 1, "R1");  // scratch entry 63 is zero
    // R2: move from immediate and register
    issue(4'd0, 4'd1, 4'd0, 8'h7F, 1, "R2");
    issue(4'd0, 4'd2, 4'd0, 8'h81, 1, "R2");
    issue(4'd0, 4'd0, 4'd1, 8'hEE, 0, "R2");
    // R3: add / add with carry
    issue(4'd1, 4'd1, 4'd2, 8'h00, 0, "R3");   // 7F+81 -> 00, C=1, Z=1
    issue(4'd2, 4'd0, 4'd0, 8'h10, 1, "R3");   // 7F+10+1 -> 90
    issue(4'd2, 4'd5, 4'd0, 8'hFF, 1, "R3");   // 0+FF+0
    // R4: subtract / with borrow
    issue(4'd3, 4'd2, 4'd0, 8'h82, 1, "R4");   // 81-82 -> FF, C=1
    issue(4'd4, 4'd2, 4'd0, 8'h00, 1, "R4");   // FF-0-1 -> FE
    issue(4'd4, 4'd6, 4'd0, 8'h00, 1, "R4");   // 0-0-0
    // R5: logic clears carry
    issue(4'd3, 4'd6, 4'd0, 8'h01, 1, "R4");   // set carry
    issue(4'd5, 4'd2, 4'd0, 8'h0F, 1, "R5");
    issue(4'd3, 4'd6, 4'd0, 8'h01, 1, "R4");
    issue(4'd6, 4'd2, 4'd0, 8'h30, 1, "R5");
    issue(4'd7, 4'd2, 4'd2, 8'h00, 0, "R5");   // XOR self -> 0
    // R6: compare keeps sX
    issue(4'd8, 4'd1, 4'd0, 8'h01, 1, "R6");
    issue(4'd6, 4'd1, 4'd0, 8'h00, 1, "R6");
    issue(4'd8, 4'd0, 4'd0, 8'h90, 1, "R6");
    issue(4'd8, 4'd0, 4'd0, 8'h10, 1, "R6");
    // R7: test parity and zero, sX unchanged
    issue(4'd9, 4'd0, 4'd0, 8'hF0, 1, "R7");
    issue(4'd9, 4'd0, 4'd0, 8'h10, 1, "R7");
    issue(4'd9, 4'd0, 4'd0, 8'h0F, 1, "R7");
    issue(4'd6, 4'd0, 4'd0, 8'h00, 1, "R7");
    // R8: shifts and rotates, operand ignored
    issue(4'd0, 4'd7, 4'd0, 8'h96, 1, "R2");
    issue(4'd10, 4'd7, 4'd0, 8'hFF, 1, "R8");
    issue(4'd11, 4'd7, 4'd0, 8'hAA, 1, "R8");
    issue(4'd12, 4'd7, 4'd0, 8'h55, 0, "R8");
    issue(4'd0, 4'd7, 4'd0, 8'h81, 1, "R2");
    issue(4'd13, 4'd7, 4'd0, 8'h00, 1, "R8");
    issue(4'd12, 4'd7, 4'd0, 8'h00, 1, "R8");
    issue(4'd0, 4'd8, 4'd0, 8'h01, 1, "R2");
    issue(4'd11, 4'd8, 4'd0, 8'h00, 1, "R9");  // shift to zero, Z=1, C=1
    // R10: store with immediate, fetch with register address
    issue(4'd0, 4'd9, 4'd0, 8'hA5, 1, "R2");
    issue(4'd14, 4'd9, 4'd0, 8'hC5, 1, "R10");
    issue(4'd0, 4'd10, 4'd0, 8'h45, 1, "R2");
    issue(4'd15, 4'd11, 4'd10, 8'h00, 0, "R10");
    issue(4'd14, 4'd7, 4'd10, 8'h00, 0, "R10");
    issue(4'd15, 4'd12, 4'd0, 8'h05, 1, "R10");
    idle(4);
    // R11: idle cycles leave flags and registers alone
    check(res_valid == 0, "R11", "res_valid idle", res_valid, 0);
    check(zero == m_z, "R11", "zero idle", zero, m_z);
    check(carry == m_c, "R11", "carry idle", carry, m_c);
    issue(4'd6, 4'd12, 4'd0, 8'h00, 1, "R11");
    idle(3);
    check(q.size() == 0, "R11", "pending results", q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule